// File: doc/BRIEF.md
# Dual-Channel MDIO Management Slave

This block is a management-bus slave for the two-wire MDIO/MDC interface with Clause 22 framing. One pair of management pins serves two independent channels. Each channel has its own small bank of 16-bit registers. A 4-bit strap input fixes the upper four bits of the port address. The slave therefore answers two adjacent port addresses, and the lowest port-address bit of a frame steers the access to channel A (0) or channel B (1).

MDC and MDIO are oversampled in the system clock domain. Frames are parsed on the detected rising edges of MDC. Read data is launched on the detected falling edges, through a data/output-enable pair meant for a tristate pad.

Bit 15 of register 0 in each channel is a power-down control. It is brought out on a port. Setting it in one or both channels changes nothing about how the management interface answers. A frame that is malformed or addressed elsewhere is dropped, and the slave waits for a fresh preamble.

Top module: `mdio_dual_slave`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `mdio_oe` is 0 and both `chan_pdown` bits are 0. Reset does not otherwise clear register contents.
- R2: A frame is accepted only when at least 32 consecutive 1 bits precede its start bits. A frame with 31 such bits gets no read response, and its write has no effect. Longer preambles (for example 40 bits) are accepted.
- R3: The start field must be the bit pair 0 then 1, and the opcode must be 01 (write) or 10 (read), first bit first. Any other start or opcode value makes the slave ignore the frame.
- R4: The slave acts on a frame only if its 5-bit port address, bits [4:1], equals `strap_addr[3:0]`. Other addresses get no response and change no register. A new strap value takes effect for the next frame.
- R5: With a matching address, port-address bit 0 = 0 accesses the channel A bank and bit 0 = 1 accesses the channel B bank. The two banks hold independent values.
- R6: On a matching read, `mdio_oe` rises after the first turnaround bit. The slave drives 0 for the second turnaround bit, then the 16 data bits MSB first, and releases the line after the last data bit. That is 17 driven bit periods in all.
- R7: On a matching write, the 16 data bits following the turnaround are taken MSB first. The addressed register updates after the last data bit, on a rising MDC edge.
- R8: Register addresses at or above NREGS (default 8, addresses 8..31) read as 0x0000. Writes to them are discarded and do not alias onto implemented registers.
- R9: Writing register 0 sets `chan_pdown[ch]` to bit 15 of the written data (bit 0 of the port for channel A, bit 1 for channel B). Register 0 reads back that bit in position 15. Reads, writes and read drive of MDIO behave unchanged while either or both channels are powered down.
- R10: `mdio_o` and `mdio_oe` change only in the low phase of MDC, after a falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample MDC and MDIO |
| rst | input | 1 | Synchronous active-high reset |
| strap_addr | input | 4 | Strapped upper four port-address bits |
| mdc | input | 1 | Management clock from the bus master |
| mdio_i | input | 1 | Management data as seen at the pad |
| mdio_o | output | 1 | Management data driven by the slave |
| mdio_oe | output | 1 | Output enable for the tristate pad, 1 = drive |
| chan_pdown | output | 2 | Power-down control per channel, bit 0 = A, bit 1 = B |

## Verification
The checks on drive timing assume several conditions about the inputs:
- Each MDC half period lasts at least six system clocks. Only then do the synchroniser, the edge register and the output register settle before the next MDC edge.
- The master changes MDIO only shortly after an MDC falling edge.
- The strap changes only between frames.

The stimulus keeps to all of this. It toggles MDC every eight clocks on the falling system clock edge, and it changes the master's data 1 ns after each MDC fall. Every frame starts with one 0 bit, so that idle ones left over from the previous frame never count toward the next preamble.

// File: rtl/mdio_dual_pkg.sv
package mdio_dual_pkg;

  // Fixed by the Clause 22 frame layout
  localparam int DATA_W  = 16;
  localparam int FIELD_W = 5;
  localparam int STRAP_W = FIELD_W - 1;
  localparam int NUM_CH  = 2;

  typedef enum logic [2:0] {
    S_HUNT,   // counting preamble ones, waiting for first start bit
    S_ST2,    // second start bit
    S_OP,     // two opcode bits
    S_PA,     // five port-address bits
    S_RA,     // five register-address bits
    S_TA,     // two turnaround bits
    S_RDATA,  // slave shifting out read data
    S_WDATA   // master shifting in write data
  } fsm_t;

  localparam logic [1:0] OP_WR = 2'b01;
  localparam logic [1:0] OP_RD = 2'b10;

endpackage

// File: rtl/mdio_edge_sync.sv
module mdio_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic mdc,
  input  logic mdio_i,
  output logic mdc_rise,
  output logic mdc_fall,
  output logic mdio_bit
);

  localparam int CLK_W = STAGES + 1;

  logic [CLK_W-1:0]  mdc_sr;
  logic [STAGES-1:0] dat_sr;

  // Resynchronise both pins. One extra tap on MDC gives the edge detector.
  always_ff @(posedge clk) begin
    if (rst) begin
      mdc_sr <= '0;
      dat_sr <= '1;
    end else begin
      mdc_sr <= {mdc_sr[CLK_W-2:0], mdc};
      dat_sr <= {dat_sr[STAGES-2:0], mdio_i};
    end
  end

  // Registered edge strobes. The data bit is aligned with the rising strobe.
  always_ff @(posedge clk) begin
    if (rst) begin
      mdc_rise <= 1'b0;
      mdc_fall <= 1'b0;
      mdio_bit <= 1'b1;
    end else begin
      mdc_rise <= mdc_sr[STAGES-1] & ~mdc_sr[STAGES];
      mdc_fall <= ~mdc_sr[STAGES-1] & mdc_sr[STAGES];
      mdio_bit <= dat_sr[STAGES-1];
    end
  end

endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
  import mdio_dual_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bit_rise,
  input  logic               bit_fall,
  input  logic               bit_val,
  input  logic [STRAP_W-1:0] strap,
  input  logic [DATA_W-1:0]  rd_word,
  output logic               mdio_o,
  output logic               mdio_oe,
  output logic               acc_ch,
  output logic [FIELD_W-1:0] acc_ra,
  output logic               wr_en,
  output logic [DATA_W-1:0]  wr_data
);

  localparam int PC_W  = $clog2(PRE_LEN + 1);
  localparam int CNT_W = $clog2(DATA_W) + 1;
  localparam int SH_W  = DATA_W - 1;

  localparam logic [PC_W-1:0]  PRE_FULL  = PC_W'(PRE_LEN);
  localparam logic [CNT_W-1:0] FIELD_END = CNT_W'(FIELD_W - 1);
  localparam logic [CNT_W-1:0] DATA_END  = CNT_W'(DATA_W - 1);

  fsm_t             state;
  logic [PC_W-1:0]  pre_cnt;
  logic [CNT_W-1:0] cnt;
  logic [SH_W-1:0]  sh;
  logic             is_rd;

  // Bit index of the read word for the current data slot (MSB first)
  logic [$clog2(DATA_W)-1:0] rd_idx;
  assign rd_idx = ~cnt[$clog2(DATA_W)-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_HUNT;
      pre_cnt <= '0;
      cnt     <= '0;
      sh      <= '0;
      is_rd   <= 1'b0;
      acc_ch  <= 1'b0;
      acc_ra  <= '0;
      wr_en   <= 1'b0;
      wr_data <= '0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
    end else begin
      wr_en <= 1'b0;

      // ---------------- frame parsing on MDC rising edges ----------------
      if (bit_rise) begin
        unique case (state)
          S_HUNT: begin
            if (bit_val) begin
              if (pre_cnt != PRE_FULL) pre_cnt <= pre_cnt + 1'b1;
            end else begin
              // a zero is the first start bit only after a full preamble
              if (pre_cnt == PRE_FULL) state <= S_ST2;
              pre_cnt <= '0;
            end
          end

          S_ST2: begin
            cnt <= '0;
            state <= bit_val ? S_OP : S_HUNT;
          end

          S_OP: begin
            sh  <= {sh[SH_W-2:0], bit_val};
            cnt <= cnt + 1'b1;
            if (cnt != '0) begin
              cnt <= '0;
              if ({sh[0], bit_val} == OP_WR) begin
                is_rd <= 1'b0;
                state <= S_PA;
              end else if ({sh[0], bit_val} == OP_RD) begin
                is_rd <= 1'b1;
                state <= S_PA;
              end else begin
                state <= S_HUNT;
              end
            end
          end

          S_PA: begin
            sh  <= {sh[SH_W-2:0], bit_val};
            cnt <= cnt + 1'b1;
            if (cnt == FIELD_END) begin
              cnt <= '0;
              if (sh[STRAP_W-1:0] == strap) begin
                acc_ch <= bit_val;   // address LSB steers the channel
                state  <= S_RA;
              end else begin
                state  <= S_HUNT;
              end
            end
          end

          S_RA: begin
            sh  <= {sh[SH_W-2:0], bit_val};
            cnt <= cnt + 1'b1;
            if (cnt == FIELD_END) begin
              cnt    <= '0;
              acc_ra <= {sh[FIELD_W-2:0], bit_val};
              state  <= S_TA;
            end
          end

          S_TA: begin
            cnt <= cnt + 1'b1;
            if (cnt != '0) begin
              cnt   <= '0;
              state <= is_rd ? S_RDATA : S_WDATA;
            end
          end

          S_RDATA: begin
            cnt <= cnt + 1'b1;
            if (cnt == DATA_END) begin
              cnt   <= '0;
              state <= S_HUNT;
            end
          end

          S_WDATA: begin
            sh  <= {sh[SH_W-2:0], bit_val};
            cnt <= cnt + 1'b1;
            if (cnt == DATA_END) begin
              cnt     <= '0;
              wr_en   <= 1'b1;
              wr_data <= {sh, bit_val};
              state   <= S_HUNT;
            end
          end

          default: state <= S_HUNT;
        endcase
      end

      // ---------------- read drive on MDC falling edges ----------------
      if (bit_fall) begin
        if (state == S_TA && is_rd && cnt != '0) begin
          mdio_oe <= 1'b1;
          mdio_o  <= 1'b0;
        end else if (state == S_RDATA) begin
          mdio_oe <= 1'b1;
          mdio_o  <= rd_word[rd_idx];
        end else begin
          mdio_oe <= 1'b0;
          mdio_o  <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/mdio_chan_regs.sv
module mdio_chan_regs #(
  parameter int NREGS = 8,
  parameter int RA_W  = 5,
  parameter int DW    = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [RA_W-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          pdown
);

  localparam int IDX_W = (NREGS > 1) ? $clog2(NREGS) : 1;

  // Plain array without reset so it maps onto distributed or block RAM
  logic [DW-1:0]    mem [NREGS];
  logic [DW-1:0]    rd_q;
  logic             hit_q;
  logic             zero_q;
  logic             hit;
  logic [IDX_W-1:0] idx;

  assign hit = (int'(addr) < NREGS);
  assign idx = addr[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (wr_en && hit) mem[idx] <= wdata;
    rd_q <= mem[idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q  <= 1'b0;
      zero_q <= 1'b0;
      pdown  <= 1'b0;
    end else begin
      hit_q  <= hit;
      zero_q <= (addr == '0);
      if (wr_en && addr == '0) pdown <= wdata[DW-1];
    end
  end

  // Register 0 bit DW-1 is the resettable power-down flop
  always_comb begin
    if (!hit_q)      rdata = '0;
    else if (zero_q) rdata = {pdown, rd_q[DW-2:0]};
    else             rdata = rd_q;
  end

endmodule

// File: rtl/mdio_dual_slave.sv
module mdio_dual_slave
  import mdio_dual_pkg::*;
#(
  parameter int PRE_LEN     = 32,
  parameter int NREGS       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [STRAP_W-1:0] strap_addr,
  input  logic               mdc,
  input  logic               mdio_i,
  output logic               mdio_o,
  output logic               mdio_oe,
  output logic [NUM_CH-1:0]  chan_pdown
);

  logic               s_rise;
  logic               s_fall;
  logic               s_bit;
  logic               acc_ch;
  logic [FIELD_W-1:0] acc_ra;
  logic               wr_en;
  logic [DATA_W-1:0]  wr_data;
  logic [DATA_W-1:0]  rd_word;
  logic [DATA_W-1:0]  bank_rd [NUM_CH];

  mdio_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .mdc      (mdc),
    .mdio_i   (mdio_i),
    .mdc_rise (s_rise),
    .mdc_fall (s_fall),
    .mdio_bit (s_bit)
  );

  mdio_frame_fsm #(.PRE_LEN(PRE_LEN)) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .bit_rise (s_rise),
    .bit_fall (s_fall),
    .bit_val  (s_bit),
    .strap    (strap_addr),
    .rd_word  (rd_word),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .acc_ch   (acc_ch),
    .acc_ra   (acc_ra),
    .wr_en    (wr_en),
    .wr_data  (wr_data)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    mdio_chan_regs #(
      .NREGS (NREGS),
      .RA_W  (FIELD_W),
      .DW    (DATA_W)
    ) u_regs (
      .clk   (clk),
      .rst   (rst),
      .wr_en (wr_en && (acc_ch == 1'(g))),
      .addr  (acc_ra),
      .wdata (wr_data),
      .rdata (bank_rd[g]),
      .pdown (chan_pdown[g])
    );
  end

  assign rd_word = bank_rd[acc_ch];

endmodule

// File: rtl/mdio_dual_slave_chk.sv
module mdio_dual_slave_chk (
  input logic       clk,
  input logic       rst,
  input logic       mdc,
  input logic       mdio_o,
  input logic       mdio_oe,
  input logic [1:0] chan_pdown
);

  localparam logic [4:0] MAX_DRIVEN = 5'd17;

  logic       mdc_d;
  logic [4:0] drv_rises;

  // Count MDC rising edges seen while the slave is driving
  always_ff @(posedge clk) begin
    mdc_d <= mdc;
    if (rst || !mdio_oe)
      drv_rises <= '0;
    else if (mdc && !mdc_d && drv_rises != 5'd31)
      drv_rises <= drv_rises + 5'd1;
  end

  // R1: line released and power-down cleared by reset
  p_float_in_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> (!mdio_oe && chan_pdown == 2'b00));

  // R10: drive changes only land while MDC is low
  p_drive_on_fall_r10: assert property (@(posedge clk) disable iff (rst)
    (!$stable(mdio_oe) || !$stable(mdio_o)) |-> !mdc);

  // R6: one read drives for at most turnaround plus 16 data bits
  p_read_window_r6: assert property (@(posedge clk) disable iff (rst)
    mdio_oe |-> (drv_rises <= MAX_DRIVEN));

  // R7: register updates land after a rising MDC edge
  p_write_on_rise_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(chan_pdown) |-> mdc);

endmodule

bind mdio_dual_slave mdio_dual_slave_chk chk_i (
  .clk        (clk),
  .rst        (rst),
  .mdc        (mdc),
  .mdio_o     (mdio_o),
  .mdio_oe    (mdio_oe),
  .chan_pdown (chan_pdown)
);

// File: tb/mdio_dual_slave_tb_top.sv
`timescale 1ns/1ps
module mdio_dual_slave_tb_top;

  localparam int HALF_MDC = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mdc = 1'b0;
  logic       m_bit = 1'b1;
  logic [3:0] strap = 4'b1010;
  logic       mdio_o;
  logic       mdio_oe;
  logic [1:0] chan_pdown;
  wire        mdio_line = mdio_oe ? mdio_o : m_bit;

  int compared = 0;
  int mismatched = 0;
  int resp_cnt = 0;
  logic [16:0] exp_q[$];
  string       tag_q[$];

  mdio_dual_slave dut_i (
    .clk        (clk),
    .rst        (rst),
    .strap_addr (strap),
    .mdc        (mdc),
    .mdio_i     (mdio_line),
    .mdio_o     (mdio_o),
    .mdio_oe    (mdio_oe),
    .chan_pdown (chan_pdown)
  );

  always #2.5 clk = ~clk;   // 200 MHz

  initial forever begin
    repeat (HALF_MDC) @(negedge clk);
    mdc = ~mdc;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  // Monitor: gather driven bits at MDC rise, compare each completed word
  initial begin
    logic [16:0] w;
    int n;
    w = '0;
    n = 0;
    forever begin
      @(posedge mdc);
      if (mdio_oe) begin
        w = {w[15:0], mdio_o};
        n++;
      end else if (n > 0) begin
        resp_cnt++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6 unexpected response", {15'd0, w}, 32'd0);
        end else begin
          logic [16:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(n == 17 && w == e, t, {n[14:0], w}, {15'd17, e});
        end
        n = 0;
      end
    end
  end

  task automatic send_bit(input logic b);
    @(negedge mdc);
    #1 m_bit = b;
  endtask

  task automatic send_frame(input int pre, input logic [1:0] st, input logic [1:0] op,
                            input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] wd);
    send_bit(1'b0);   // break any run of idle ones
    for (int i = 0; i < pre; i++) send_bit(1'b1);
    for (int i = 1; i >= 0; i--) send_bit(st[i]);
    for (int i = 1; i >= 0; i--) send_bit(op[i]);
    for (int i = 4; i >= 0; i--) send_bit(pa[i]);
    for (int i = 4; i >= 0; i--) send_bit(ra[i]);
    if (op == 2'b10) begin
      for (int i = 0; i < 18; i++) send_bit(1'b1);
    end else begin
      send_bit(1'b1);
      send_bit(1'b0);
      for (int i = 15; i >= 0; i--) send_bit(wd[i]);
    end
    send_bit(1'b1);
    send_bit(1'b1);
    @(posedge mdc);
    @(posedge mdc);
  endtask

  task automatic wr(input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] d);
    send_frame(32, 2'b01, 2'b01, pa, ra, d);
  endtask

  // Driver: expected word (turnaround 0 then data) goes to the scoreboard
  task automatic rd(input int pre, input logic [4:0] pa, input logic [4:0] ra,
                    input logic [15:0] exp, input string tag);
    exp_q.push_back({1'b0, exp});
    tag_q.push_back(tag);
    send_frame(pre, 2'b01, 2'b10, pa, ra, 16'h0);
  endtask

  task automatic no_resp(input int pre, input logic [1:0] st, input logic [1:0] op,
                         input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] d,
                         input string tag);
    int c0;
    c0 = resp_cnt;
    send_frame(pre, st, op, pa, ra, d);
    chk(resp_cnt == c0 && !mdio_oe, tag, resp_cnt, c0);
  endtask

  localparam logic [4:0] PA_A = 5'b10100;
  localparam logic [4:0] PA_B = 5'b10101;

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(mdio_oe == 1'b0, "R1 oe in reset", mdio_oe, 0);
    chk(chan_pdown == 2'b00, "R1 pdown in reset", chan_pdown, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(mdio_oe == 1'b0, "R1 oe after reset", mdio_oe, 0);

    // R5 R7 R6: basic writes and reads on both channels
    wr(PA_A, 5'd1, 16'h1234);
    wr(PA_B, 5'd1, 16'hABCD);
    rd(32, PA_A, 5'd1, 16'h1234, "R5 R7 channel A reg1");
    rd(32, PA_B, 5'd1, 16'hABCD, "R5 channel B reg1");
    wr(PA_A, 5'd3, 16'h8001);
    rd(32, PA_A, 5'd3, 16'h8001, "R6 R10 MSB first turnaround 0");
    wr(PA_B, 5'd3, 16'h7FFE);
    rd(32, PA_B, 5'd3, 16'h7FFE, "R6 bit order B");

    // R2: preamble length
    send_frame(31, 2'b01, 2'b01, PA_A, 5'd1, 16'hFFFF);
    rd(32, PA_A, 5'd1, 16'h1234, "R2 short-preamble write ignored");
    no_resp(31, 2'b01, 2'b10, PA_A, 5'd1, 16'h0, "R2 short-preamble read");
    rd(40, PA_B, 5'd1, 16'hABCD, "R2 long preamble accepted");

    // R3: start and opcode
    no_resp(32, 2'b00, 2'b10, PA_A, 5'd1, 16'h0, "R3 bad start 00");
    no_resp(32, 2'b11, 2'b10, PA_A, 5'd1, 16'h0, "R3 bad start 11");
    no_resp(32, 2'b01, 2'b00, PA_A, 5'd1, 16'h0F0F, "R3 opcode 00");
    no_resp(32, 2'b01, 2'b11, PA_A, 5'd1, 16'h0F0F, "R3 opcode 11");
    rd(32, PA_A, 5'd1, 16'h1234, "R3 bad-opcode writes ignored");

    // R4: address match against strap
    no_resp(32, 2'b01, 2'b10, 5'b10110, 5'd1, 16'h0, "R4 foreign address read");
    no_resp(32, 2'b01, 2'b01, 5'b00100, 5'd1, 16'h5A5A, "R4 foreign address write");
    rd(32, PA_A, 5'd1, 16'h1234, "R4 foreign write ignored");
    strap = 4'b0011;
    rd(32, 5'b00111, 5'd1, 16'hABCD, "R4 new strap channel B");
    no_resp(32, 2'b01, 2'b10, PA_B, 5'd1, 16'h0, "R4 old address after strap change");
    strap = 4'b1010;

    // R8: unimplemented registers
    rd(32, PA_A, 5'd8, 16'h0000, "R8 read reg8");
    rd(32, PA_B, 5'd31, 16'h0000, "R8 read reg31");
    wr(PA_A, 5'd9, 16'h5555);
    rd(32, PA_A, 5'd1, 16'h1234, "R8 no alias onto reg1");
    rd(32, PA_A, 5'd9, 16'h0000, "R8 write discarded");

    // R9: power-down control
    wr(PA_A, 5'd0, 16'h8000);
    chk(chan_pdown == 2'b01, "R9 pdown A set", chan_pdown, 2'b01);
    wr(PA_B, 5'd0, 16'h8123);
    chk(chan_pdown == 2'b11, "R9 pdown both set", chan_pdown, 2'b11);
    rd(32, PA_A, 5'd1, 16'h1234, "R9 read while both down");
    rd(32, PA_B, 5'd0, 16'h8123, "R9 reg0 readback");
    wr(PA_A, 5'd2, 16'h00FF);
    rd(32, PA_A, 5'd2, 16'h00FF, "R9 write while both down");
    wr(PA_A, 5'd0, 16'h0000);
    chk(chan_pdown == 2'b10, "R9 pdown A cleared", chan_pdown, 2'b10);
    rd(32, PA_A, 5'd0, 16'h0000, "R9 reg0 A cleared");

    // R1: reset again clears power-down but not stored data
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(mdio_oe == 1'b0, "R1 oe in second reset", mdio_oe, 0);
    chk(chan_pdown == 2'b00, "R1 pdown cleared", chan_pdown, 0);
    rst = 1'b0;
    rd(32, PA_B, 5'd0, 16'h0123, "R1 reg0 after reset");

    chk(exp_q.size() == 0, "R6 all expected reads answered", exp_q.size(), 0);
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

endmodule